// File: doc/BRIEF.md
# Pipelined Gravitational Force Datapath

This block evaluates the inverse-square attraction between two point masses in fixed-point arithmetic: the product of a constant gain with both masses, divided by the squared distance between the two positions. Each operator of the formula sits in its own register stage, so a fresh input set can enter on every clock. Results leave in the order of entry, one per clock, after a fixed latency.

The two coordinate differences are formed side by side, turned into magnitudes, squared, and then added to give the denominator. The mass product and its scaling by the gain constant run in a parallel branch of equal depth. Both operands therefore reach a restoring divider in the same cycle. The divider settles one quotient bit per stage. A final register stage replaces the result of a zero denominator with the all-ones code and raises a flag.

Input and output are a valid-qualified stream with no back-pressure. An input set is taken on every clock edge where `in_valid` is high, and the result cannot be stalled. A consumer must accept every cycle where `out_valid` is high.

Top module: `grav_force_pipe`

## Requirements
- R1: With a nonzero denominator, `force_q` equals floor(G_VAL·m1·m2 / ((x1−x2)² + (y1−y2)²)), with coordinates taken as two's-complement and masses as unsigned.
- R2: `out_valid` rises exactly LATENCY = NW+4 clocks after the edge that samples `in_valid` high (28 with default parameters), and never without a matching input.
- R3: Input sets given on consecutive clocks produce results on consecutive clocks, in the same order, with none lost.
- R4: When both coordinate differences are zero, the result carries `force_q` all ones and `div_by_zero` = 1.
- R5: While `out_valid` is low, `force_q` is 0 and `div_by_zero` is 0; for a result with a nonzero denominator, `div_by_zero` is 0.
- R6: Coordinate differences are formed at full signed range, so operands at opposite extremes (−2^(CW−1) against 2^(CW−1)−1) give the exact squared distance.
- R7: While `rst_n` is low, `out_valid` is 0. Input sets still in flight when reset is asserted never produce a result.
- R8: A zero mass with a nonzero denominator gives `force_q` = 0 and `div_by_zero` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input set present this cycle |
| x1 | input | CW | First body, horizontal position (signed) |
| x2 | input | CW | Second body, horizontal position (signed) |
| y1 | input | CW | First body, vertical position (signed) |
| y2 | input | CW | Second body, vertical position (signed) |
| m1 | input | MW | First body mass (unsigned) |
| m2 | input | MW | Second body mass (unsigned) |
| out_valid | output | 1 | Result present this cycle |
| force_q | output | 2·MW+GW | Quotient, or all ones on a zero denominator |
| div_by_zero | output | 1 | Result had a zero denominator |

## Verification
Every result is due exactly 28 clocks after the edge that takes its input set. The scoreboard stamps each expected item with the clock count at which it was driven plus that latency. The monitor samples on the falling edge and compares both the value and the arrival clock against the head of the queue. Any result that arrives when nothing is expected, including after a mid-flight reset, counts as a failure. Cycles with `out_valid` low are also checked for cleared outputs.

// File: rtl/gf_pkg.sv
package gf_pkg;
  // Stages in front of the divider: magnitude, square, sum
  localparam int unsigned PRE_DIV_STAGES  = 3;
  // Stages after the divider: zero-denominator substitution
  localparam int unsigned POST_DIV_STAGES = 1;

  // Width of a sum of two squared CW-bit magnitudes
  function automatic int unsigned sum_width(input int unsigned cw);
    return 2 * cw + 1;
  endfunction

  // Width of gain times two masses
  function automatic int unsigned num_width(input int unsigned mw, input int unsigned gw);
    return 2 * mw + gw;
  endfunction
endpackage

// File: rtl/gf_dist_lane.sv
module gf_dist_lane #(
  parameter int unsigned CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [CW-1:0] pa,
  input  logic signed [CW-1:0] pb,
  output logic [2*CW-1:0]      sq
);
  logic signed [CW:0] diff;
  logic [CW-1:0]      mag_q;

  // Difference needs one extra bit to cover the full signed span
  always_comb diff = {pa[CW-1], pa} - {pb[CW-1], pb};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q <= '0;
      sq    <= '0;
    end else begin
      mag_q <= diff[CW] ? CW'(-diff) : diff[CW-1:0];
      sq    <= {{CW{1'b0}}, mag_q} * {{CW{1'b0}}, mag_q};
    end
  end
endmodule

// File: rtl/gf_mass_path.sv
module gf_mass_path #(
  parameter int unsigned MW    = 8,
  parameter int unsigned GW    = 8,
  parameter int unsigned G_VAL = 13,
  parameter int unsigned NW    = 2 * MW + GW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] m1,
  input  logic [MW-1:0] m2,
  output logic [NW-1:0] num
);
  localparam logic [NW-1:0] GAIN = NW'(G_VAL);

  logic [2*MW-1:0] prod_q;
  logic [NW-1:0]   scaled_q;

  // Depth matches the distance branch: product, scale, align
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q   <= '0;
      scaled_q <= '0;
      num      <= '0;
    end else begin
      prod_q   <= {{MW{1'b0}}, m1} * {{MW{1'b0}}, m2};
      scaled_q <= {{GW{1'b0}}, prod_q} * GAIN;
      num      <= scaled_q;
    end
  end
endmodule

// File: rtl/gf_div_stage.sv
module gf_div_stage #(
  parameter int unsigned NW = 24,
  parameter int unsigned DW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic          zf_i,
  input  logic [DW-1:0] rem_i,
  input  logic [NW-1:0] num_i,
  input  logic [NW-1:0] quo_i,
  input  logic [DW-1:0] den_i,
  output logic          vld_o,
  output logic          zf_o,
  output logic [DW-1:0] rem_o,
  output logic [NW-1:0] num_o,
  output logic [NW-1:0] quo_o,
  output logic [DW-1:0] den_o
);
  logic [DW:0] trial;
  logic [DW:0] less;
  logic        take;

  // One restoring step: bring down the next dividend bit, try a subtract
  always_comb begin
    trial = {rem_i, num_i[NW-1]};
    take  = trial >= {1'b0, den_i};
    less  = trial - {1'b0, den_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      zf_o  <= 1'b0;
      rem_o <= '0;
      num_o <= '0;
      quo_o <= '0;
      den_o <= '0;
    end else begin
      vld_o <= vld_i;
      zf_o  <= zf_i;
      rem_o <= take ? less[DW-1:0] : trial[DW-1:0];
      num_o <= {num_i[NW-2:0], 1'b0};
      quo_o <= {quo_i[NW-2:0], take};
      den_o <= den_i;
    end
  end
endmodule

// File: rtl/grav_force_pipe.sv
module grav_force_pipe
  import gf_pkg::*;
#(
  parameter int unsigned CW    = 8,
  parameter int unsigned MW    = 8,
  parameter int unsigned GW    = 8,
  parameter int unsigned G_VAL = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [CW-1:0] x1,
  input  logic signed [CW-1:0] x2,
  input  logic signed [CW-1:0] y1,
  input  logic signed [CW-1:0] y2,
  input  logic [MW-1:0]        m1,
  input  logic [MW-1:0]        m2,
  output logic                 out_valid,
  output logic [2*MW+GW-1:0]   force_q,
  output logic                 div_by_zero
);
  localparam int unsigned DW      = sum_width(CW);
  localparam int unsigned NW      = num_width(MW, GW);
  localparam int unsigned LATENCY = PRE_DIV_STAGES + NW + POST_DIV_STAGES;

  // Distance branch: two identical lanes, one per axis
  logic signed [CW-1:0] lane_a  [2];
  logic signed [CW-1:0] lane_b  [2];
  logic [2*CW-1:0]      lane_sq [2];

  assign lane_a[0] = x1;
  assign lane_b[0] = x2;
  assign lane_a[1] = y1;
  assign lane_b[1] = y2;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    gf_dist_lane #(.CW(CW)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .pa    (lane_a[g]),
      .pb    (lane_b[g]),
      .sq    (lane_sq[g])
    );
  end

  // Mass branch, same depth as the distance branch
  logic [NW-1:0] num;

  gf_mass_path #(.MW(MW), .GW(GW), .G_VAL(G_VAL), .NW(NW)) u_mass (
    .clk   (clk),
    .rst_n (rst_n),
    .m1    (m1),
    .m2    (m2),
    .num   (num)
  );

  // Valid travels beside the front-end data
  logic [PRE_DIV_STAGES-1:0] v_q;
  logic [DW-1:0]             den_q;
  logic                      zf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      den_q <= '0;
      zf_q  <= 1'b0;
    end else begin
      v_q   <= {v_q[PRE_DIV_STAGES-2:0], in_valid};
      den_q <= {1'b0, lane_sq[0]} + {1'b0, lane_sq[1]};
      zf_q  <= (lane_sq[0] == '0) && (lane_sq[1] == '0);
    end
  end

  // Divider chain: stage k settles quotient bit NW-1-k
  logic          c_vld [NW+1];
  logic          c_zf  [NW+1];
  logic [DW-1:0] c_rem [NW+1];
  logic [NW-1:0] c_num [NW+1];
  logic [NW-1:0] c_quo [NW+1];
  logic [DW-1:0] c_den [NW+1];

  assign c_vld[0] = v_q[PRE_DIV_STAGES-1];
  assign c_zf[0]  = zf_q;
  assign c_rem[0] = '0;
  assign c_num[0] = num;
  assign c_quo[0] = '0;
  assign c_den[0] = den_q;

  for (genvar k = 0; k < NW; k++) begin : g_div
    gf_div_stage #(.NW(NW), .DW(DW)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (c_vld[k]),
      .zf_i  (c_zf[k]),
      .rem_i (c_rem[k]),
      .num_i (c_num[k]),
      .quo_i (c_quo[k]),
      .den_i (c_den[k]),
      .vld_o (c_vld[k+1]),
      .zf_o  (c_zf[k+1]),
      .rem_o (c_rem[k+1]),
      .num_o (c_num[k+1]),
      .quo_o (c_quo[k+1]),
      .den_o (c_den[k+1])
    );
  end

  // Output stage: saturate on zero denominator, clear when idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      force_q     <= '0;
      div_by_zero <= 1'b0;
    end else begin
      out_valid   <= c_vld[NW];
      div_by_zero <= c_vld[NW] && c_zf[NW];
      if (!c_vld[NW])    force_q <= '0;
      else if (c_zf[NW]) force_q <= '1;
      else               force_q <= c_quo[NW];
    end
  end
endmodule

// File: rtl/gf_chk.sv
module gf_chk #(
  parameter int unsigned LAT = 28,
  parameter int unsigned NW  = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic          div_by_zero,
  input logic [NW-1:0] force_q
);
  // History of accepted inputs, cleared by reset
  logic [LAT-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[LAT-2:0], in_valid};
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == hist[LAT-1]);

  // R4
  zero_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_by_zero |-> (out_valid && force_q == '1));

  // R5
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (force_q == '0 && !div_by_zero));

  // R7
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!out_valid);
    end
  end
endmodule

bind grav_force_pipe gf_chk #(.LAT(LATENCY), .NW(NW)) u_gf_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .div_by_zero (div_by_zero),
  .force_q     (force_q)
);

// File: tb/test_grav_force_pipe.sv
module test_grav_force_pipe;
  localparam int CW = 8;
  localparam int MW = 8;
  localparam int GW = 8;
  localparam int G_VAL = 13;
  localparam int NW = 2 * MW + GW;
  localparam int LAT = NW + 4;
  localparam longint ALL1 = (longint'(1) << NW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [CW-1:0] x1 = '0, x2 = '0, y1 = '0, y2 = '0;
  logic [MW-1:0] m1 = '0, m2 = '0;
  logic out_valid;
  logic [NW-1:0] force_q;
  logic div_by_zero;

  always #2.5 clk = ~clk;

  grav_force_pipe #(.CW(CW), .MW(MW), .GW(GW), .G_VAL(G_VAL)) i_grav_force_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x1(x1), .x2(x2), .y1(y1), .y2(y2), .m1(m1), .m2(m2),
    .out_valid(out_valid), .force_q(force_q), .div_by_zero(div_by_zero)
  );

  int n_cmp = 0;
  int n_bad = 0;
  longint cyc = 0;
  bit done = 1'b0;

  longint q_val[$];
  bit     q_dz[$];
  longint q_due[$];
  string  q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: one input set per call, expected result pushed to the scoreboard
  task automatic send(input int ax1, input int ax2, input int ay1, input int ay2,
                      input int am1, input int am2, input string tag);
    longint dx, dy, den, num;
    @(negedge clk);
    x1 = CW'(ax1); x2 = CW'(ax2); y1 = CW'(ay1); y2 = CW'(ay2);
    m1 = MW'(am1); m2 = MW'(am2);
    in_valid = 1'b1;
    dx = longint'(ax1) - longint'(ax2);
    dy = longint'(ay1) - longint'(ay2);
    den = dx * dx + dy * dy;
    num = longint'(G_VAL) * longint'(am1) * longint'(am2);
    if (den == 0) begin
      q_val.push_back(ALL1); q_dz.push_back(1'b1);
    end else begin
      q_val.push_back(num / den); q_dz.push_back(1'b0);
    end
    q_due.push_back(cyc + LAT);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compares every result against the scoreboard head
  always @(negedge clk) begin
    if (!done) begin
      if (out_valid) begin
        if (q_val.size() == 0) begin
          check(1'b0, "R2/R7 unexpected result", 1, 0);
        end else begin
          longint ev, ed; bit ez; string t;
          ev = q_val.pop_front(); ez = q_dz.pop_front();
          ed = q_due.pop_front(); t = q_tag.pop_front();
          check(cyc == ed, "R2 arrival cycle", cyc, ed);
          check(longint'(force_q) == ev, t, longint'(force_q), ev);
          check(div_by_zero == ez, (ez ? "R4 flag" : "R5 flag"), div_by_zero, ez);
        end
      end else if (rst_n) begin
        check(force_q == '0 && !div_by_zero, "R5 idle outputs", force_q, 0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check(!out_valid, "R7 reset out_valid", out_valid, 0);
    check(force_q == '0, "R7 reset force_q", force_q, 0);
    rst_n = 1'b1;
    idle(4);

    // R1 single set: 13*200/25 = 104
    send(3, 0, 4, 0, 10, 20, "R1 basic");
    idle(LAT + 3);
    // R4 zero denominator
    send(-7, -7, 50, 50, 100, 3, "R4 zero denominator");
    // R6 extremes: 13*65025/130050 = 6
    send(-128, 127, -128, 127, 255, 255, "R6 extreme span");
    send(127, -128, 0, 0, 1, 1, "R6 extreme span one axis");
    // R8 zero mass
    send(5, 1, -2, 9, 0, 77, "R8 zero mass");
    // R1 largest quotient: denominator 1
    send(1, 0, 0, 0, 255, 255, "R1 unit denominator");
    idle(LAT + 3);

    // R3 back-to-back stream
    for (int i = 0; i < 40; i++) begin
      send($urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 255), $urandom_range(0, 255), "R3 stream");
    end
    // Gapped traffic
    for (int i = 0; i < 20; i++) begin
      send($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
           $urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
           "R1 gapped");
      idle(i % 4);
    end
    idle(LAT + 3);
    check(q_val.size() == 0, "R3 all delivered", q_val.size(), 0);

    // R7: reset with sets in flight
    for (int i = 0; i < 6; i++) send(i, 0, 0, 0, 9, 9, "R7 flushed");
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    q_val.delete(); q_dz.delete(); q_due.delete(); q_tag.delete();
    idle(3);
    rst_n = 1'b1;
    idle(LAT + 5);
    send(0, 2, 0, 0, 4, 4, "R1 after reset");
    idle(LAT + 3);
    check(q_val.size() == 0, "R3 all delivered after reset", q_val.size(), 0);
    finish_run();
  end
endmodule